// File: doc/BRIEF.md
# Sign-Extending Scaling Shifter

This block scales a 16-bit data word into the 32-bit accumulator path. It shifts the word left by between 0 and 16 places, and the shift count arrives with each operation. The low positions that the shift vacates always take zeros. A mode input decides how the high positions are filled: with copies of input bit 15, or with zeros.

The block is built from a small control module and a datapath module under a thin top. The control module clamps the count and works out the fill. The datapath module is a logarithmic shifter. A parameter can add one output register for timing. In that case the result and the out-of-range flag arrive exactly one clock later.

Top module: `scaleShifter`

## Requirements
- R1: For an effective shift of k, result bits k-1 down to 0 are always zero.
- R2: For a count c from 0 to 16, the result equals the extended input shifted left by c places.
- R3: With signExtEn = 0, every result bit above position 15+k is zero, so the unsigned result equals dataIn × 2^k.
- R4: With signExtEn = 1, the result read as a signed 32-bit number equals signed dataIn × 2^k, so a negative input gives result bit 31 = 1.
- R5: shiftCnt is a 5-bit field. A count above 16 is treated as 16 and raises rangeErr; a count of 16 or less leaves rangeErr at 0.
- R6: A shift of 16 places dataIn in bits 31:16 and leaves bits 15:0 at zero, whatever the mode.
- R7: With PIPE_EN = 0, resultOut and rangeErr are a pure function of the present inputs, valid in the same cycle.
- R8: With PIPE_EN = 1, resultOut and rangeErr carry the values for the inputs present at the previous rising clock edge. While rstN is low both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low asynchronous reset of the output register |
| dataIn | input | 16 | Data word to scale |
| shiftCnt | input | 5 | Left shift amount for this operation |
| signExtEn | input | 1 | 1 fills the high bits with copies of dataIn[15]; 0 fills them with zeros |
| resultOut | output | 32 | Scaled result |
| rangeErr | output | 1 | Count was above 16 and was clamped |

## Verification
The combinational build produces its result in the same cycle. The bench changes the inputs on a falling edge and checks that build 1 ns later, before any clock edge. The registered build produces its result one cycle later. Its inputs are held across the next rising edge, and it is checked at the following falling edge. Reset is checked by applying nonzero inputs while rstN is low and confirming that the registered outputs stay at zero.

// File: rtl/scale_shifter_pkg.sv
`timescale 1ns/1ps
package scale_shifter_pkg;
  localparam int DATA_W    = 16;
  localparam int OUT_W     = 32;
  localparam int CNT_W     = 5;
  localparam int MAX_SHIFT = 16;
  localparam int SH_W      = $clog2(MAX_SHIFT + 1);
  localparam int EXT_W     = OUT_W - DATA_W;

  typedef struct packed {
    logic [SH_W-1:0] amount;    // clamped shift amount
    logic            fillOnes;  // upper fill is ones
    logic            clamped;   // request exceeded MAX_SHIFT
  } shiftCtrl_t;
endpackage

// File: rtl/scale_shifter_ctrl.sv
`timescale 1ns/1ps
module scaleShifterCtrl
  import scale_shifter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] shiftCnt,
  input  logic             signExtEn,
  input  logic             dataMsb,
  output shiftCtrl_t       ctrl
);
  logic overLimit;

  always_comb begin
    overLimit     = (int'(shiftCnt) > MAX_SHIFT);
    ctrl.clamped  = overLimit;
    ctrl.amount   = overLimit ? SH_W'(MAX_SHIFT) : SH_W'(shiftCnt);
    ctrl.fillOnes = signExtEn & dataMsb;
  end

  // R5: the amount handed on never exceeds the limit
  p_amount_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    int'(ctrl.amount) <= MAX_SHIFT);

  // R5: a clamped request always runs at the full limit
  p_clamp_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clamped |-> (int'(ctrl.amount) == MAX_SHIFT));
endmodule

// File: rtl/scale_shifter_dp.sv
`timescale 1ns/1ps
module scaleShifterDp
  import scale_shifter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  shiftCtrl_t        ctrl,
  output logic [OUT_W-1:0]  wideOut
);
  logic [OUT_W-1:0] stage [SH_W+1];

  assign stage[0] = {{EXT_W{ctrl.fillOnes}}, dataIn};

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign stage[k+1] = ctrl.amount[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  assign wideOut = stage[SH_W];

  // R1: the vacated low positions are zero
  p_low_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wideOut & ((OUT_W'(1) << ctrl.amount) - OUT_W'(1))) == '0);

  // R3: with zero fill nothing appears above the shifted word
  p_top_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.fillOnes |-> ((wideOut >> (DATA_W + int'(ctrl.amount))) == '0));

  // R4: a negative extended input stays negative
  p_sign_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.fillOnes |-> wideOut[OUT_W-1]);

  // R6: a full shift lands the input word in the upper half
  p_full_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(ctrl.amount) == MAX_SHIFT) |-> (wideOut == {dataIn, {DATA_W{1'b0}}}));
endmodule

// File: rtl/scaleShifter.sv
`timescale 1ns/1ps
module scaleShifter
  import scale_shifter_pkg::*;
#(
  parameter bit PIPE_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CNT_W-1:0]  shiftCnt,
  input  logic              signExtEn,
  output logic [OUT_W-1:0]  resultOut,
  output logic              rangeErr
);
  shiftCtrl_t       ctrl;
  logic [OUT_W-1:0] combOut;

  scaleShifterCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .shiftCnt  (shiftCnt),
    .signExtEn (signExtEn),
    .dataMsb   (dataIn[DATA_W-1]),
    .ctrl      (ctrl)
  );

  scaleShifterDp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .ctrl    (ctrl),
    .wideOut (combOut)
  );

  if (PIPE_EN) begin : g_pipe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resultOut <= '0;
        rangeErr  <= 1'b0;
      end else begin
        resultOut <= combOut;
        rangeErr  <= ctrl.clamped;
      end
    end

    // R8: registered outputs trail the shifter by exactly one cycle
    p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> (resultOut == $past(combOut) && rangeErr == $past(ctrl.clamped)));
  end else begin : g_comb
    assign resultOut = combOut;
    assign rangeErr  = ctrl.clamped;

    // R7: combinational outputs follow the shifter directly
    p_same_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
      (resultOut == combOut) && (rangeErr == (int'(shiftCnt) > MAX_SHIFT)));
  end
endmodule

// File: tb/scaleShifter_bench.sv
`timescale 1ns/1ps
module scaleShifter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] dataIn = '0;
  logic [4:0]  shiftCnt = '0;
  logic        signExtEn = 1'b0;
  logic [31:0] pipeOut, combOut;
  logic        pipeErr, combErr;
  int          checkCount = 0;
  int          failCount = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  scaleShifter #(.PIPE_EN(1'b1)) u_scaleShifter (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .shiftCnt(shiftCnt),
    .signExtEn(signExtEn), .resultOut(pipeOut), .rangeErr(pipeErr));

  scaleShifter #(.PIPE_EN(1'b0)) u_scaleShifterComb (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .shiftCnt(shiftCnt),
    .signExtEn(signExtEn), .resultOut(combOut), .rangeErr(combErr));

  function automatic logic [31:0] expResult(logic [15:0] d, logic [4:0] c, logic s);
    int          k = (c > 16) ? 16 : int'(c);
    logic [31:0] ext = s ? {{16{d[15]}}, d} : {16'h0, d};
    return ext << k;
  endfunction

  function automatic string tagFor(logic [4:0] c, logic s);
    if (c > 16) return "R5";
    if (c == 16) return "R6";
    return s ? "R4" : "R3";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic applyVec(logic [15:0] d, logic [4:0] c, logic s);
    logic [31:0] e = expResult(d, c, s);
    int k = (c > 16) ? 16 : int'(c);
    @(negedge clk);
    dataIn = d; shiftCnt = c; signExtEn = s;
    #1;
    check({"R7/R2/", tagFor(c, s)}, combOut, e);
    check("R7/R5 flag", {31'b0, combErr}, {31'b0, c > 16});
    check("R1 low bits", combOut & ((32'd1 << k) - 32'd1), 32'd0);
    @(negedge clk);
    check("R8 data", pipeOut, e);
    check("R8/R5 flag", {31'b0, pipeErr}, {31'b0, c > 16});
  endtask

  initial begin
    #400000;
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R8: held at zero in reset despite live inputs
    dataIn = 16'hBEEF; shiftCnt = 5'd3; signExtEn = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset data", pipeOut, 32'd0);
    check("R8 reset flag", {31'b0, pipeErr}, 32'd0);
    rstN = 1'b1;

    applyVec(16'h8000, 5'd0, 1'b1);   // R4: FFFF8000
    applyVec(16'h8000, 5'd16, 1'b1);  // R6: 80000000
    applyVec(16'hFFFF, 5'd16, 1'b0);  // R6: FFFF0000
    applyVec(16'h1234, 5'd31, 1'b1);  // R5: clamp, 12340000
    applyVec(16'h8001, 5'd17, 1'b0);  // R5: clamp, 80010000
    applyVec(16'h7FFF, 5'd15, 1'b1);  // R4: positive stays positive
    applyVec(16'hF000, 5'd15, 1'b0);  // R3: no sign bits
    applyVec(16'h0001, 5'd1, 1'b0);   // R2
    for (int i = 0; i < 400; i++)
      applyVec(16'($urandom), 5'($urandom), 1'($urandom));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end
endmodule